// File: doc/BRIEF.md
# Byte Register-File ALU

This block holds thirty-two 8-bit working registers and a single-issue arithmetic and logic unit. Each request arrives already decoded. It carries an operation code, a destination index, a source index and an 8-bit immediate. The block executes the request, writes the result back into the register file, and updates two flags: carry and zero. A combinational observation port returns the contents of any register.

Most operations finish in one clock. Multiply and the 16-bit register-pair add and subtract take two clocks. While one of those runs, `busy` is high, and any request presented in that time is dropped. Every accepted request ends in a one-cycle pulse: `done` for a legal request, or `illegal` for a request whose operand indices or immediate fall outside the range its operation allows. The carry-chained add, subtract and compare let software process multi-byte values one byte at a time, starting with the low byte.

Operation codes are numbered in the order of the package enumeration `balu_op_e`, from 0 (`OP_ADD`) to 25 (`OP_SBIW`).

Control runs in a two-state machine:
- `S_IDLE` accepts requests. On a legal multiply or pair request, transition `IDLE_TO_WIDE` latches the operands and moves to `S_WIDE`. Any other request stays in `S_IDLE` (transition `IDLE_HOLD`).
- `S_WIDE` writes both result bytes and always returns to idle (transition `WIDE_TO_IDLE`).

Top module: `byte_alu_rf`

## Requirements
- R1: Reset sets every register, `flag_c` and `flag_z` to 0, puts control in `S_IDLE`, and drives `busy`, `done` and `illegal` low.
- R2: `OP_ADD`, `OP_SUB`, `OP_AND`, `OP_OR`, `OP_EOR` and `OP_MOV` accept any of the 32 registers for both operands. Add and subtract set carry to the carry-out or borrow and set zero when the 8-bit result is 0. The logic operations set zero and leave carry unchanged. `OP_MOV` copies the source and leaves both flags unchanged.
- R3: `OP_ADC` computes dst + src + carry and `OP_SBC` computes dst - src - carry. Both set carry to the carry-out or borrow of the full operation.
- R4: For `OP_SBC`, `OP_SBCI` and `OP_CPC`, zero becomes 0 when the result is nonzero and otherwise keeps its previous value.
- R5: The immediate forms `OP_LDI`, `OP_SUBI`, `OP_SBCI`, `OP_ANDI`, `OP_ORI`, `OP_CPI` and `OP_SER` accept only destinations 16 to 31.
- R6: `OP_INC` and `OP_DEC` add or subtract 1, update zero and keep carry. `OP_COM` gives 0xFF - dst and sets carry. `OP_NEG` gives 0x00 - dst, leaving 0x80 as 0x80, and sets carry when the result is nonzero. `OP_CLR` gives dst XOR dst and sets zero. `OP_SER` loads 0xFF and keeps both flags.
- R7: `OP_CP`, `OP_CPC` and `OP_CPI` set the flags exactly as the matching subtract would and change no register.
- R8: `OP_MUL` (unsigned) and `OP_MULS` (signed) write the 16-bit product to R1 (high byte) and R0 (low byte), even when R0 or R1 was a source. They set carry to product bit 15 and zero when the product is 0. `OP_MULS` accepts only operands 16 to 31.
- R9: `OP_ADIW` and `OP_SBIW` add or subtract an immediate of 0 to 63 to or from the pair dst+1:dst, with dst being 26, 28 or 30. Carry is the 16-bit carry-out or borrow, and zero is set when the 16-bit result is 0.
- R10: A request with an out-of-range index, a pair immediate above 63, or an unassigned opcode (26 to 31) changes no register and no flag. It raises `illegal` for one cycle instead of `done`.
- R11: A one-cycle request raises `done` in the cycle after it is accepted. A multiply or pair request holds `busy` for exactly one cycle and raises `done` one cycle later. Requests presented while `busy` is high are ignored.
- R12: `OP_LDI` loads the immediate into the destination and keeps both flags. `obs_data` always shows the register selected by `obs_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present |
| req_op | input | 5 | Operation code |
| req_dst | input | 5 | Destination / first operand index |
| req_src | input | 5 | Source / second operand index |
| req_imm | input | 8 | Immediate operand |
| obs_idx | input | 5 | Register selected for observation |
| obs_data | output | 8 | Contents of the observed register |
| busy | output | 1 | A two-cycle operation is in progress |
| done | output | 1 | Pulse: the previous request completed |
| illegal | output | 1 | Pulse: the previous request was rejected |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |

## Verification
Two functions can fall in the same clock. The first is the second-cycle write of a pair or multiply operation. The second is the acceptance of a new request, since a requester may present a fresh one while `busy` is still high. The bench provokes this by issuing a pair add on R31:R30 and then, during its busy cycle, driving a load of 0x77 into R30. The pass criterion is that R30:R31 hold only the pair result and that a single `done` pulse follows. A related overlap, where the multiply writes R1:R0 while those same registers are its sources, is judged by comparing R1 against the product of the old values.

// File: rtl/balu_pkg.sv
package balu_pkg;

    typedef enum logic [4:0] {
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_AND, OP_OR, OP_EOR, OP_MOV,
        OP_CP, OP_CPC, OP_INC, OP_DEC, OP_COM, OP_NEG, OP_CLR, OP_SER,
        OP_LDI, OP_SUBI, OP_SBCI, OP_ANDI, OP_ORI, OP_CPI,
        OP_MUL, OP_MULS, OP_ADIW, OP_SBIW
    } balu_op_e;

    typedef enum logic {S_IDLE, S_WIDE} balu_state_e;

    // operations whose second operand is the immediate, upper-half destination only
    function automatic logic op_is_imm(input balu_op_e op);
        return op inside {OP_LDI, OP_SUBI, OP_SBCI, OP_ANDI, OP_ORI, OP_CPI, OP_SER};
    endfunction

    // operations that take two cycles
    function automatic logic op_is_wide(input balu_op_e op);
        return op inside {OP_MUL, OP_MULS, OP_ADIW, OP_SBIW};
    endfunction

    function automatic logic op_is_mul(input balu_op_e op);
        return op inside {OP_MUL, OP_MULS};
    endfunction

    // borrow-chained forms with the sticky zero rule
    function automatic logic op_is_chained(input balu_op_e op);
        return op inside {OP_SBC, OP_SBCI, OP_CPC};
    endfunction

endpackage

// File: rtl/balu_regfile.sv
module balu_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 32,
    parameter int NRD  = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0][AW-1:0]  rd_idx,
    output logic [NRD-1:0][DW-1:0]  rd_dat,
    input  logic                    wa_en,
    input  logic [AW-1:0]           wa_idx,
    input  logic [DW-1:0]           wa_dat,
    input  logic                    wb_en,
    input  logic [AW-1:0]           wb_idx,
    input  logic [DW-1:0]           wb_dat
);

    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (wa_en) mem[wa_idx] <= wa_dat;
            if (wb_en) mem[wb_idx] <= wb_dat;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_dat[g] = mem[rd_idx[g]];
    end

    // R8: the two write ports never target the same register in one cycle
    assert_write_ports_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa_en && wb_en && wa_idx == wb_idx));

endmodule

// File: rtl/balu_alu.sv
module balu_alu
    import balu_pkg::*;
#(
    parameter int DW = 8
) (
    input  balu_op_e       op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [DW-1:0]  imm,
    input  logic           c_in,
    input  logic           z_in,
    output logic [DW-1:0]  res,
    output logic           c_out,
    output logic           z_out,
    output logic           wr
);

    logic [DW-1:0] opnd;
    logic [DW:0]   sum_e;
    logic [DW:0]   dif_e;
    logic [DW:0]   one_e;

    always_comb begin
        opnd  = op_is_imm(op) ? imm : b;
        one_e = {{DW{1'b0}}, 1'b1};
        sum_e = {1'b0, a} + {1'b0, opnd} + {{DW{1'b0}}, (op == OP_ADC) & c_in};
        dif_e = {1'b0, a} - {1'b0, opnd} - {{DW{1'b0}}, op_is_chained(op) & c_in};
        res   = a;
        c_out = c_in;
        z_out = z_in;
        wr    = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                res   = sum_e[DW-1:0];
                c_out = sum_e[DW];
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_SUB, OP_SUBI, OP_CP, OP_CPI: begin
                res   = dif_e[DW-1:0];
                c_out = dif_e[DW];
                z_out = (res == '0);
                wr    = (op == OP_SUB) || (op == OP_SUBI);
            end
            OP_SBC, OP_SBCI, OP_CPC: begin
                res   = dif_e[DW-1:0];
                c_out = dif_e[DW];
                z_out = z_in & (res == '0);
                wr    = (op != OP_CPC);
            end
            OP_AND, OP_ANDI: begin
                res   = a & opnd;
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_OR, OP_ORI: begin
                res   = a | opnd;
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_EOR, OP_CLR: begin
                res   = (op == OP_CLR) ? (a ^ a) : (a ^ opnd);
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_MOV, OP_LDI: begin
                res = opnd;
                wr  = 1'b1;
            end
            OP_INC: begin
                res   = a + one_e[DW-1:0];
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_DEC: begin
                res   = a - one_e[DW-1:0];
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_COM: begin
                res   = ~a;
                c_out = 1'b1;
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_NEG: begin
                res   = '0 - a;
                c_out = (res != '0);
                z_out = (res == '0);
                wr    = 1'b1;
            end
            OP_SER: begin
                res = '1;
                wr  = 1'b1;
            end
            default: begin
                res = a;
            end
        endcase
    end

endmodule

// File: rtl/balu_wide.sv
module balu_wide
    import balu_pkg::*;
#(
    parameter int DW = 8,
    parameter int KW = 6
) (
    input  balu_op_e       op,
    input  logic [DW-1:0]  lo_in,
    input  logic [DW-1:0]  hi_in,
    input  logic [DW-1:0]  b,
    input  logic [KW-1:0]  k,
    output logic [DW-1:0]  lo_out,
    output logic [DW-1:0]  hi_out,
    output logic           c_out,
    output logic           z_out
);

    localparam int PW = 2 * DW;

    logic [PW-1:0] prod_u;
    logic [PW-1:0] prod_s;
    logic [PW:0]   word_e;
    logic [PW:0]   k_e;
    logic [PW-1:0] out_w;

    always_comb begin
        prod_u = {{DW{1'b0}}, lo_in} * {{DW{1'b0}}, b};
        prod_s = {{DW{lo_in[DW-1]}}, lo_in} * {{DW{b[DW-1]}}, b};
        k_e    = {{(PW + 1 - KW){1'b0}}, k};
        word_e = (op == OP_SBIW) ? ({1'b0, hi_in, lo_in} - k_e)
                                 : ({1'b0, hi_in, lo_in} + k_e);
        if (op_is_mul(op)) begin
            out_w = (op == OP_MULS) ? prod_s : prod_u;
            c_out = out_w[PW-1];
        end else begin
            out_w = word_e[PW-1:0];
            c_out = word_e[PW];
        end
        z_out  = (out_w == '0);
        lo_out = out_w[DW-1:0];
        hi_out = out_w[PW-1:DW];
    end

endmodule

// File: rtl/byte_alu_rf.sv
module byte_alu_rf
    import balu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REG_CNT = 32,
    parameter int KIMM_W  = 6,
    localparam int AW     = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [4:0]        req_op,
    input  logic [AW-1:0]     req_dst,
    input  logic [AW-1:0]     req_src,
    input  logic [DATA_W-1:0] req_imm,
    input  logic [AW-1:0]     obs_idx,
    output logic [DATA_W-1:0] obs_data,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              flag_c,
    output logic              flag_z
);

    localparam logic [AW-1:0] HALF_IDX  = AW'(REG_CNT / 2);
    localparam logic [AW-1:0] PAIR0_IDX = AW'(REG_CNT - 6);
    localparam logic [AW-1:0] R0_IDX    = AW'(0);
    localparam logic [AW-1:0] R1_IDX    = AW'(1);

    balu_op_e    op;
    balu_state_e state_q, state_d;

    logic                    code_ok, idx_ok, legal, accept, go_ok, go_bad, is_wide;
    logic [3:0][AW-1:0]      rd_idx;
    logic [3:0][DATA_W-1:0]  rd_dat;

    logic                    wa_en, wb_en;
    logic [AW-1:0]           wa_idx, wb_idx;
    logic [DATA_W-1:0]       wa_dat, wb_dat;

    logic [DATA_W-1:0]       alu_res;
    logic                    alu_c, alu_z, alu_wr;

    balu_op_e                w_op;
    logic [AW-1:0]           w_dst;
    logic [DATA_W-1:0]       w_lo, w_hi, w_b;
    logic [KIMM_W-1:0]       w_k;
    logic [DATA_W-1:0]       wide_lo, wide_hi;
    logic                    wide_c, wide_z;

    logic                    flag_ld, c_d, z_d;

    // ---------------- request legality ----------------
    always_comb begin
        op      = balu_op_e'(req_op);
        code_ok = (req_op <= OP_SBIW);
        is_wide = op_is_wide(op);
        if (op_is_imm(op)) begin
            idx_ok = (req_dst >= HALF_IDX);
        end else if (op == OP_MULS) begin
            idx_ok = (req_dst >= HALF_IDX) && (req_src >= HALF_IDX);
        end else if (op == OP_ADIW || op == OP_SBIW) begin
            idx_ok = (req_dst >= PAIR0_IDX) && !req_dst[0]
                     && (req_imm[DATA_W-1:KIMM_W] == '0);
        end else begin
            idx_ok = 1'b1;
        end
        legal  = code_ok && idx_ok;
        accept = req_valid && (state_q == S_IDLE);
        go_ok  = accept && legal;
        go_bad = accept && !legal;
    end

    // ---------------- datapath pieces ----------------
    assign rd_idx[0] = req_dst;
    assign rd_idx[1] = req_src;
    assign rd_idx[2] = {req_dst[AW-1:1], 1'b1};
    assign rd_idx[3] = obs_idx;
    assign obs_data  = rd_dat[3];

    balu_regfile #(.DW(DATA_W), .NREG(REG_CNT), .NRD(4)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (rd_idx),
        .rd_dat (rd_dat),
        .wa_en  (wa_en),
        .wa_idx (wa_idx),
        .wa_dat (wa_dat),
        .wb_en  (wb_en),
        .wb_idx (wb_idx),
        .wb_dat (wb_dat)
    );

    balu_alu #(.DW(DATA_W)) u_alu (
        .op    (op),
        .a     (rd_dat[0]),
        .b     (rd_dat[1]),
        .imm   (req_imm),
        .c_in  (flag_c),
        .z_in  (flag_z),
        .res   (alu_res),
        .c_out (alu_c),
        .z_out (alu_z),
        .wr    (alu_wr)
    );

    balu_wide #(.DW(DATA_W), .KW(KIMM_W)) u_wide (
        .op     (w_op),
        .lo_in  (w_lo),
        .hi_in  (w_hi),
        .b      (w_b),
        .k      (w_k),
        .lo_out (wide_lo),
        .hi_out (wide_hi),
        .c_out  (wide_c),
        .z_out  (wide_z)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state and write controls ----------------
    always_comb begin
        state_d = state_q;
        wa_en   = 1'b0;
        wa_idx  = req_dst;
        wa_dat  = alu_res;
        wb_en   = 1'b0;
        wb_idx  = {w_dst[AW-1:1], 1'b1};
        wb_dat  = wide_hi;
        flag_ld = 1'b0;
        c_d     = alu_c;
        z_d     = alu_z;
        unique case (state_q)
            S_IDLE: begin
                if (go_ok && is_wide) begin
                    state_d = S_WIDE;             // IDLE_TO_WIDE
                end else if (go_ok) begin
                    wa_en   = alu_wr;             // IDLE_HOLD with write-back
                    flag_ld = 1'b1;
                end
            end
            S_WIDE: begin
                state_d = S_IDLE;                 // WIDE_TO_IDLE
                wa_en   = 1'b1;
                wb_en   = 1'b1;
                wa_idx  = op_is_mul(w_op) ? R0_IDX : w_dst;
                wb_idx  = op_is_mul(w_op) ? R1_IDX : {w_dst[AW-1:1], 1'b1};
                wa_dat  = wide_lo;
                flag_ld = 1'b1;
                c_d     = wide_c;
                z_d     = wide_z;
            end
        endcase
    end

    // ---------------- registered outputs and operand latch ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_c  <= 1'b0;
            flag_z  <= 1'b0;
            done    <= 1'b0;
            illegal <= 1'b0;
            w_op    <= OP_MUL;
            w_dst   <= '0;
            w_lo    <= '0;
            w_hi    <= '0;
            w_b     <= '0;
            w_k     <= '0;
        end else begin
            if (flag_ld) begin
                flag_c <= c_d;
                flag_z <= z_d;
            end
            done    <= (go_ok && !is_wide) || (state_q == S_WIDE);
            illegal <= go_bad;
            if (go_ok && is_wide) begin
                w_op  <= op;
                w_dst <= req_dst;
                w_lo  <= rd_dat[0];
                w_hi  <= rd_dat[2];
                w_b   <= rd_dat[1];
                w_k   <= req_imm[KIMM_W-1:0];
            end
        end
    end

    assign busy = (state_q == S_WIDE);

    // ---------------- assertions ----------------
    // R11: the two-cycle path occupies exactly one busy cycle
    assert_busy_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R11: a request shown while busy is neither accepted nor rejected
    assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> !illegal);

    // R10: completion and rejection are exclusive
    assert_done_xor_illegal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));

    // R10: a rejected request leaves the flags as they were
    assert_illegal_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(flag_c) && $stable(flag_z)));

    // R4: a cleared zero flag stays cleared through a chained subtract or compare
    assert_zero_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_ok && op_is_chained(op) && !flag_z) |=> !flag_z);

endmodule

// File: tb/byte_alu_rf_tb.sv
module byte_alu_rf_tb;
    import balu_pkg::*;

    typedef struct packed {
        logic [4:0] op;
        logic [4:0] dst;
        logic [4:0] src;
        logic [7:0] imm;
        logic [4:0] chk;
        logic [7:0] val;
        logic       c;
        logic       z;
        logic       ill;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 53;
    localparam vec_t VEC [NV] = '{
        '{OP_LDI , 5'd16, 5'd0 , 8'h3C, 5'd16, 8'h3C, 1'b0, 1'b0, 1'b0, 4'd12}, // R12
        '{OP_LDI , 5'd17, 5'd0 , 8'hC8, 5'd17, 8'hC8, 1'b0, 1'b0, 1'b0, 4'd12},
        '{OP_ADD , 5'd16, 5'd17, 8'h00, 5'd16, 8'h04, 1'b1, 1'b0, 1'b0, 4'd2 }, // R2 carry out
        '{OP_LDI , 5'd18, 5'd0 , 8'hFF, 5'd18, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd12},
        '{OP_LDI , 5'd20, 5'd0 , 8'h01, 5'd20, 8'h01, 1'b1, 1'b0, 1'b0, 4'd12},
        '{OP_LDI , 5'd19, 5'd0 , 8'h00, 5'd19, 8'h00, 1'b1, 1'b0, 1'b0, 4'd12},
        '{OP_LDI , 5'd21, 5'd0 , 8'h00, 5'd21, 8'h00, 1'b1, 1'b0, 1'b0, 4'd12},
        '{OP_ADD , 5'd18, 5'd20, 8'h00, 5'd18, 8'h00, 1'b1, 1'b1, 1'b0, 4'd2 },
        '{OP_ADC , 5'd19, 5'd21, 8'h00, 5'd19, 8'h01, 1'b0, 1'b0, 1'b0, 4'd3 }, // R3
        '{OP_LDI , 5'd23, 5'd0 , 8'h01, 5'd23, 8'h01, 1'b0, 1'b0, 1'b0, 4'd12},
        '{OP_LDI , 5'd25, 5'd0 , 8'h01, 5'd25, 8'h01, 1'b0, 1'b0, 1'b0, 4'd12},
        '{OP_SUB , 5'd22, 5'd24, 8'h00, 5'd22, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2 },
        '{OP_SBC , 5'd23, 5'd25, 8'h00, 5'd23, 8'h00, 1'b0, 1'b1, 1'b0, 4'd4 }, // R4 zero kept
        '{OP_CP  , 5'd16, 5'd20, 8'h00, 5'd16, 8'h04, 1'b0, 1'b0, 1'b0, 4'd7 }, // R7
        '{OP_CPC , 5'd19, 5'd20, 8'h00, 5'd19, 8'h01, 1'b0, 1'b0, 1'b0, 4'd4 }, // R4 zero stays 0
        '{OP_CPI , 5'd17, 5'd0 , 8'hC9, 5'd17, 8'hC8, 1'b1, 1'b0, 1'b0, 4'd7 },
        '{OP_SBCI, 5'd17, 5'd0 , 8'h00, 5'd17, 8'hC7, 1'b0, 1'b0, 1'b0, 4'd3 },
        '{OP_SUBI, 5'd17, 5'd0 , 8'hC7, 5'd17, 8'h00, 1'b0, 1'b1, 1'b0, 4'd5 }, // R5
        '{OP_ORI , 5'd16, 5'd0 , 8'hF0, 5'd16, 8'hF4, 1'b0, 1'b0, 1'b0, 4'd5 },
        '{OP_ANDI, 5'd16, 5'd0 , 8'h0F, 5'd16, 8'h04, 1'b0, 1'b0, 1'b0, 4'd5 },
        '{OP_EOR , 5'd16, 5'd16, 8'h00, 5'd16, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2 },
        '{OP_OR  , 5'd16, 5'd20, 8'h00, 5'd16, 8'h01, 1'b0, 1'b0, 1'b0, 4'd2 },
        '{OP_AND , 5'd16, 5'd17, 8'h00, 5'd16, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2 },
        '{OP_INC , 5'd16, 5'd0 , 8'h00, 5'd16, 8'h01, 1'b0, 1'b0, 1'b0, 4'd6 }, // R6
        '{OP_DEC , 5'd16, 5'd0 , 8'h00, 5'd16, 8'h00, 1'b0, 1'b1, 1'b0, 4'd6 },
        '{OP_DEC , 5'd16, 5'd0 , 8'h00, 5'd16, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd6 },
        '{OP_COM , 5'd16, 5'd0 , 8'h00, 5'd16, 8'h00, 1'b1, 1'b1, 1'b0, 4'd6 },
        '{OP_LDI , 5'd16, 5'd0 , 8'h80, 5'd16, 8'h80, 1'b1, 1'b1, 1'b0, 4'd12},
        '{OP_NEG , 5'd16, 5'd0 , 8'h00, 5'd16, 8'h80, 1'b1, 1'b0, 1'b0, 4'd6 },
        '{OP_LDI , 5'd16, 5'd0 , 8'h05, 5'd16, 8'h05, 1'b1, 1'b0, 1'b0, 4'd12},
        '{OP_NEG , 5'd16, 5'd0 , 8'h00, 5'd16, 8'hFB, 1'b1, 1'b0, 1'b0, 4'd6 },
        '{OP_CLR , 5'd16, 5'd0 , 8'h00, 5'd16, 8'h00, 1'b1, 1'b1, 1'b0, 4'd6 },
        '{OP_SER , 5'd16, 5'd0 , 8'h00, 5'd16, 8'hFF, 1'b1, 1'b1, 1'b0, 4'd6 },
        '{OP_MOV , 5'd2 , 5'd16, 8'h00, 5'd2 , 8'hFF, 1'b1, 1'b1, 1'b0, 4'd2 },
        '{OP_LDI , 5'd17, 5'd0 , 8'h12, 5'd17, 8'h12, 1'b1, 1'b1, 1'b0, 4'd12},
        '{OP_MUL , 5'd2 , 5'd17, 8'h00, 5'd0 , 8'hEE, 1'b0, 1'b0, 1'b0, 4'd8 }, // R8
        '{OP_MOV , 5'd3 , 5'd1 , 8'h00, 5'd3 , 8'h11, 1'b0, 1'b0, 1'b0, 4'd8 },
        '{OP_MULS, 5'd16, 5'd17, 8'h00, 5'd1 , 8'hFF, 1'b1, 1'b0, 1'b0, 4'd8 },
        '{OP_MUL , 5'd0 , 5'd1 , 8'h00, 5'd1 , 8'hED, 1'b1, 1'b0, 1'b0, 4'd8 },
        '{OP_MUL , 5'd22, 5'd24, 8'h00, 5'd0 , 8'h00, 1'b0, 1'b1, 1'b0, 4'd8 },
        '{OP_LDI , 5'd26, 5'd0 , 8'hFE, 5'd26, 8'hFE, 1'b0, 1'b1, 1'b0, 4'd12},
        '{OP_ADIW, 5'd26, 5'd0 , 8'h05, 5'd27, 8'h01, 1'b0, 1'b0, 1'b0, 4'd9 }, // R9
        '{OP_SBIW, 5'd26, 5'd0 , 8'h3F, 5'd26, 8'hC4, 1'b0, 1'b0, 1'b0, 4'd9 },
        '{OP_SBIW, 5'd28, 5'd0 , 8'h01, 5'd29, 8'hFF, 1'b1, 1'b0, 1'b0, 4'd9 },
        '{OP_ADIW, 5'd28, 5'd0 , 8'h01, 5'd28, 8'h00, 1'b1, 1'b1, 1'b0, 4'd9 },
        '{OP_LDI , 5'd15, 5'd0 , 8'h05, 5'd15, 8'h00, 1'b1, 1'b1, 1'b1, 4'd5 }, // R5 low dst
        '{OP_ANDI, 5'd0 , 5'd0 , 8'h00, 5'd0 , 8'h00, 1'b1, 1'b1, 1'b1, 4'd5 },
        '{OP_MULS, 5'd16, 5'd15, 8'h00, 5'd1 , 8'h00, 1'b1, 1'b1, 1'b1, 4'd8 },
        '{OP_ADIW, 5'd24, 5'd0 , 8'h01, 5'd24, 8'h00, 1'b1, 1'b1, 1'b1, 4'd9 },
        '{OP_ADIW, 5'd27, 5'd0 , 8'h01, 5'd27, 8'h00, 1'b1, 1'b1, 1'b1, 4'd9 },
        '{OP_SBIW, 5'd30, 5'd0 , 8'h40, 5'd30, 8'h00, 1'b1, 1'b1, 1'b1, 4'd9 },
        '{5'd31  , 5'd16, 5'd0 , 8'h00, 5'd16, 8'hFF, 1'b1, 1'b1, 1'b1, 4'd10}, // R10
        '{OP_SER , 5'd3 , 5'd0 , 8'h00, 5'd3 , 8'h11, 1'b1, 1'b1, 1'b1, 4'd5 }
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [4:0] req_op = '0;
    logic [4:0] req_dst = '0;
    logic [4:0] req_src = '0;
    logic [7:0] req_imm = '0;
    logic [4:0] obs_idx = '0;
    logic [7:0] obs_data;
    logic       busy, done, illegal, flag_c, flag_z;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #10 clk = ~clk;   // 50 MHz

    byte_alu_rf u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_dst   (req_dst),
        .req_src   (req_src),
        .req_imm   (req_imm),
        .obs_idx   (obs_idx),
        .obs_data  (obs_data),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .flag_c    (flag_c),
        .flag_z    (flag_z)
    );

    task automatic check(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            finish_run();
        end
    end

    // drive one request, wait out busy, leave sampling point just after completion
    task automatic issue(input logic [4:0] op, input logic [4:0] d, input logic [4:0] s, input logic [7:0] k);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_dst   = d;
        req_src   = s;
        req_imm   = k;
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 0; w < 4 && busy; w++) @(negedge clk);
    endtask

    task automatic peek(input logic [4:0] idx, output logic [7:0] v);
        obs_idx = idx;
        #1;
        v = obs_data;
    endtask

    logic [7:0] got;

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "busy/done/illegal after reset", {5'd0, busy, done, illegal}, 8'h00);
        check(1, "flags after reset", {6'd0, flag_c, flag_z}, 8'h00);
        peek(5'd31, got);
        check(1, "R31 after reset", got, 8'h00);
        peek(5'd0, got);
        check(1, "R0 after reset", got, 8'h00);

        // vector table: R2..R10, R12
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].op, VEC[i].dst, VEC[i].src, VEC[i].imm);
            check(int'(VEC[i].rq), $sformatf("vec %0d done/illegal", i),
                  {6'd0, done, illegal}, {6'd0, ~VEC[i].ill, VEC[i].ill});
            check(int'(VEC[i].rq), $sformatf("vec %0d flags c,z", i),
                  {6'd0, flag_c, flag_z}, {6'd0, VEC[i].c, VEC[i].z});
            peek(VEC[i].chk, got);
            check(int'(VEC[i].rq), $sformatf("vec %0d reg %0d", i, VEC[i].chk), got, VEC[i].val);
        end

        // R11: one-cycle done pulse and busy timing of a single-cycle op
        @(negedge clk);
        req_valid = 1'b1; req_op = OP_LDI; req_dst = 5'd24; req_imm = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0;
        check(11, "single op done next cycle", {6'd0, done, busy}, 8'h02);
        @(negedge clk);
        check(11, "done is one cycle", {7'd0, done}, 8'h00);

        // R11: request during the pair busy cycle is dropped
        @(negedge clk);
        req_valid = 1'b1; req_op = OP_ADIW; req_dst = 5'd30; req_imm = 8'h01;
        @(negedge clk);
        check(11, "pair op busy", {6'd0, busy, done}, 8'h02);
        req_op = OP_LDI; req_imm = 8'h77;          // still valid while busy
        @(negedge clk);
        req_valid = 1'b0;
        check(11, "pair op completes", {6'd0, busy, done}, 8'h01);
        check(9, "pair op flags", {6'd0, flag_c, flag_z}, 8'h00);
        peek(5'd30, got);
        check(11, "R30 holds pair result, load ignored", got, 8'h01);
        peek(5'd31, got);
        check(9, "R31 high byte", got, 8'h00);
        @(negedge clk);
        check(11, "no second completion", {6'd0, done, illegal}, 8'h00);

        // R1: reset in mid-run clears registers and flags
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(5'd24, got);
        check(1, "R24 cleared by reset", got, 8'h00);
        check(1, "flags cleared by reset", {6'd0, flag_c, flag_z}, 8'h00);

        finish_run();
    end

endmodule